// File: doc/BRIEF.md
# Two-Digit Time-Multiplexed Seven-Segment Driver

This block drives a two-digit seven-segment display whose digits share one set of seven segment lines. A single select output chooses which digit is powered, so only one digit is ever lit. The block takes one 8-bit word that holds two 4-bit values. It decodes each value into a hexadecimal glyph and switches between the two digits often enough that both appear lit at once.

A free-running prescaler flips the select line every `DIV` clock cycles. The default of 500,000 cycles gives 5 ms per digit with a 100 MHz clock. A full refresh of both digits therefore takes 10 ms, well inside the 20 ms (50 Hz) limit. The segment pattern is registered and is updated on the same edge as the select line. As a result, a digit is never shown with the glyph of the other digit.

Top module: `dual_digit_sseg`

## Requirements
- R1: While `rst_ni` is low, `seg_o` is 7'b0000000 and `sel_o` is 0, which selects the right digit.
- R2: Segments are active high, with segment a on bit 0 through segment g on bit 6. The values 0 to F decode to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71 (hex), so the value 1 shows as 7'b0000110.
- R3: After reset is released, `sel_o` first changes on the `DIV`-th rising edge. After that it changes every `DIV` rising edges and holds between those edges.
- R4: When `sel_o` is 1 (left digit), `seg_o` shows `value_i[7:4]`. When `sel_o` is 0 (right digit), `seg_o` shows `value_i[3:0]`. In both cases the value is the one sampled at the previous rising edge.
- R5: On the edge where `sel_o` changes, `seg_o` already shows the glyph of the newly selected digit. The old pattern never appears together with the new select value.
- R6: A change in the nibble of the digit that is not selected has no effect on `seg_o` until that digit is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| value_i | input | 8 | Two packed values: [7:4] for the left digit, [3:0] for the right digit |
| seg_o | output | 7 | Segment lines, active high, bit 0 = a through bit 6 = g |
| sel_o | output | 1 | Digit select: 1 = left digit, 0 = right digit |

## Verification
The hardest case to reach is a change of `value_i` on the same edge where the select line flips. On that edge the glyph must be taken from the new nibble of the newly selected digit, not from the old digit or the old value. The bench runs with a small `DIV` so that toggle edges come often. It changes the word at random on every cycle and also places directed changes exactly on the toggle edges. In a separate phase it holds the selected nibble fixed while the other nibble changes at random, which shows that the unselected nibble is ignored.

// File: rtl/sseg_pkg.sv
package sseg_pkg;
  typedef logic [3:0] nibble_t;
  typedef logic [6:0] seg_t;   // bit0 = a .. bit6 = g, active high

  function automatic seg_t hex_glyph(nibble_t v);
    seg_t s;
    unique case (v)
      4'h0: s = 7'h3f;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5b;
      4'h3: s = 7'h4f;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6d;
      4'h6: s = 7'h7d;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7f;
      4'h9: s = 7'h6f;
      4'ha: s = 7'h77;
      4'hb: s = 7'h7c;
      4'hc: s = 7'h39;
      4'hd: s = 7'h5e;
      4'he: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ssd_prescaler.sv
module ssd_prescaler #(
  parameter int unsigned DIV = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R3: counter wraps after the last count and never passes it
  a_r3_cnt_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));
  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/ssd_digit_sel.sv
module ssd_digit_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic sel_next_o,
  output logic sel_o
);
  logic sel_q;

  assign sel_next_o = sel_q ^ tick_i;
  assign sel_o      = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_next_o;
  end

  a_r3_flip_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (sel_q != $past(sel_q)));
  a_r3_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sel_q));
endmodule

// File: rtl/ssd_seg_decoder.sv
module ssd_seg_decoder
  import sseg_pkg::*;
(
  input  nibble_t val_i,
  output seg_t    seg_o
);
  assign seg_o = hex_glyph(val_i);
endmodule

// File: rtl/dual_digit_sseg.sv
module dual_digit_sseg
  import sseg_pkg::*;
#(
  parameter int unsigned DIV = 500000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] value_i,
  output logic [6:0] seg_o,
  output logic       sel_o
);
  localparam int unsigned NUM_DIG = 2;
  localparam int unsigned NIB_W   = 4;

  logic tick;
  logic sel_next;
  seg_t glyph [NUM_DIG];
  seg_t seg_q;

  ssd_prescaler #(.DIV(DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  ssd_digit_sel u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .sel_next_o(sel_next),
    .sel_o     (sel_o)
  );

  // index 0 = right digit (low nibble), index 1 = left digit (high nibble)
  for (genvar d = 0; d < NUM_DIG; d++) begin : g_dig
    ssd_seg_decoder u_dec (
      .val_i(value_i[d*NIB_W +: NIB_W]),
      .seg_o(glyph[d])
    );
  end

  // pattern follows next select so both change on the same edge (R5)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seg_q <= '0;
    else         seg_q <= sel_next ? glyph[1] : glyph[0];
  end

  assign seg_o = seg_q;

  // checker state: one edge seen since reset
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R4/R5: output glyph matches nibble chosen by current select
  a_r4_seg_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (seg_o == hex_glyph(sel_o ? $past(value_i[7:4]) : $past(value_i[3:0]))));
  // R6: selected nibble unchanged and no flip -> glyph steady
  a_r6_unsel_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !tick && (sel_o ? ($past(value_i[7:4]) == value_i[7:4])
                               : ($past(value_i[3:0]) == value_i[3:0])))
      |=> $stable(seg_o));
endmodule

// File: tb/dual_digit_sseg_tb.sv
module dual_digit_sseg_tb;
  localparam int unsigned DIV = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] value_i = 8'h00;
  logic [6:0] seg_o;
  logic       sel_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned seed  = 32'h5eed_1234;
  bit          done  = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  dual_digit_sseg #(.DIV(DIV)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .value_i(value_i),
    .seg_o  (seg_o),
    .sel_o  (sel_o)
  );

  function automatic logic [6:0] ref_glyph(logic [3:0] v);
    logic [6:0] tbl [16] = '{7'h3f, 7'h06, 7'h5b, 7'h4f, 7'h66, 7'h6d, 7'h7d, 7'h07,
                             7'h7f, 7'h6f, 7'h77, 7'h7c, 7'h39, 7'h5e, 7'h79, 7'h71};
    return tbl[v];
  endfunction

  // reference behaviour derived from R1, R3, R4, R5
  int unsigned m_edges;
  logic        m_sel;
  logic [6:0]  m_seg;
  logic        m_flip;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_edges <= 0; m_sel <= 1'b0; m_seg <= '0; m_flip <= 1'b0;
    end else begin
      logic ns;
      ns = ((m_edges + 1) % DIV == 0) ? ~m_sel : m_sel;
      m_flip  <= (ns != m_sel);
      m_sel   <= ns;
      m_seg   <= ref_glyph(ns ? value_i[7:4] : value_i[3:0]);
      m_edges <= m_edges + 1;
    end
  end

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_cycle(string tag);
    check({"R3 sel ", tag}, {6'd0, sel_o}, {6'd0, m_sel});
    if (m_flip) check({"R5 seg on flip ", tag}, seg_o, m_seg);
    else        check({"R4 seg ", tag}, seg_o, m_seg);
  endtask

  task automatic step(logic [7:0] v, string tag);
    value_i = v;
    @(negedge clk_i);
    check_cycle(tag);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
          n_bad++;
          $display("FAIL watchdog: got timeout expected completion");
          $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
          $finish;
        end
      end
    join_none

    // R1: reset state
    value_i = 8'ha5;
    repeat (3) @(negedge clk_i);
    check("R1 seg reset", seg_o, 7'h00);
    check("R1 sel reset", {6'd0, sel_o}, 7'd0);
    rst_ni = 1'b1;

    // R3: first flip on DIV-th edge
    for (int i = 1; i <= DIV; i++) begin
      @(negedge clk_i);
      check("R3 first flip", {6'd0, sel_o}, {6'd0, (i == DIV)});
    end

    // R2: every glyph on both digits
    for (int n = 0; n < 16; n++) begin
      for (int k = 0; k < 2*DIV; k++) begin
        value_i = {n[3:0], n[3:0]};
        @(negedge clk_i);
        if (k > 0) check("R2 glyph", seg_o, ref_glyph(n[3:0]));
        check_cycle("R2");
      end
    end
    // R2: digit 1 pattern explicit
    value_i = 8'h11;
    @(negedge clk_i);
    check("R2 digit one", seg_o, 7'b0000110);

    // R5: value changes placed on flip edges
    for (int r = 0; r < 40; r++) begin
      while ((m_edges + 1) % DIV != 0) step(8'h00, "R5 wait");
      step(8'($urandom(seed + r)), "R5 flip edge");
    end

    // R6: unselected nibble churns, selected nibble held
    for (int r = 0; r < 400; r++) begin
      logic [3:0] rnd;
      rnd = 4'($urandom(seed + 1000 + r));
      if (m_sel) step({4'h9, rnd}, "R6 left held");
      else       step({rnd, 4'h6}, "R6 right held");
    end

    // random mix
    for (int r = 0; r < 1500; r++)
      step(8'($urandom(seed + 5000 + r)), "rand");

    // R1: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 seg async reset", seg_o, 7'h00);
    check("R1 sel async reset", {6'd0, sel_o}, 7'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 3*DIV; i++) step(8'h3c, "R3 after reset");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule